// File: doc/BRIEF.md
# Secure Interrupt Set-Enable Register Bank

This block holds the forwarding enables for a 64-interrupt extended private range. The enables are split across two 32-bit words that are reached through a small memory-mapped register port. Writing a 1 to a bit turns forwarding on for that interrupt. Writing a 0 does nothing. The block drives the full 64-bit enable vector to the downstream forwarding logic.

Every bit is gated by an access mask before it can be read or written. The mask combines four things: the security attribute of the access, the security group of the interrupt, whether the interrupt exists, and whether affinity routing is on for the interrupt's security state. A bit that the mask closes reads as zero, and a write leaves it unchanged.

A single-cycle clear vector turns enables off for test purposes. If the clear and a register write hit the same bit in the same cycle, the write wins.

Top module: `sec_set_enable_bank`

## Requirements
- R1: Word n (n = 1, 2) sits at byte offset 0x100 + 4*n, so the two words are at 0x104 and 0x108. Bit b of the word at 0x104 drives `fwd_en[b]`, and bit b of the word at 0x108 drives `fwd_en[32+b]`. Interrupt ID m maps to word (m-1024) DIV 32 and to bit (m-1024) MOD 32.
- R2: A write (`acc_wr`=1) to a valid word sets each bit whose `acc_wdata` bit is 1 and whose mask is open, at the clock edge where `acc_wr` is high. Data bits that are 0 leave their enables unchanged.
- R3: After a read (`acc_rd`=1) of a valid word, `rd_data` holds the enable state of that word ANDed with the access mask, in the cycle after the strobe. In any cycle that does not follow a read, `rd_data` is zero.
- R4: Synchronous active-low reset clears all 64 enables and `rd_data`.
- R5: When `sec_disable`=0 and `acc_ns`=1 (Non-secure access), bits whose `irq_grp_sec` is 1 (Secure group) read as zero and ignore writes. When `sec_disable`=1, or when the access is Secure (`acc_ns`=0), these bits are open.
- R6: Bits whose `irq_present` is 0 read as zero and ignore writes, whatever the access.
- R7: A bit whose `irq_grp_sec` is 1 is open only while `route_en_sec`=1. A bit whose `irq_grp_sec` is 0 is open only while `route_en_nsec`=1. A closed bit reads as zero and ignores writes.
- R8: An access to any address other than exactly 0x104 or 0x108 changes no enable and reads as zero. This covers misaligned addresses such as 0x105, and the neighbouring offsets 0x100 and 0x10C.
- R9: Each bit of `test_clr` that is high at a clock edge clears that enable. If a masked write sets the same bit in the same cycle, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 12 | Byte address of the access within the frame |
| acc_wdata | input | 32 | Write data; each 1 requests a set |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_ns | input | 1 | 1 for a Non-secure access, 0 for a Secure access |
| rd_data | output | 32 | Registered read data |
| irq_present | input | 64 | 1 where the interrupt is implemented |
| irq_grp_sec | input | 64 | 1 where the interrupt is in the Secure group |
| sec_disable | input | 1 | Security-disable flag |
| route_en_sec | input | 1 | Affinity routing enabled for Secure state |
| route_en_nsec | input | 1 | Affinity routing enabled for Non-secure state |
| test_clr | input | 64 | Single-cycle per-bit clear |
| fwd_en | output | 64 | Forwarding enable vector |

## Verification
The bench builds the block with its default parameters: two 32-bit words, a base offset of 0x100 and a first index of 1. With these values both real word addresses can be reached, and so can the empty offsets on either side of them and a misaligned address. Directed sequences drive each mask input in turn: Secure-group bits under Non-secure and Secure access, absent interrupts, and routing turned off for one state. Randomised traffic then mixes every mask input with reads, writes and clears, so that set-versus-clear collisions and masks that change between cycles are covered in both words.

// File: rtl/sse_pkg.sv
// Shared types and the per-bit access rule for the set-enable bank.
// Assumes a 32-bit register word; all users take the width from here.
package sse_pkg;
    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Returns 1 when an interrupt bit may be read and written by this access.
    function automatic logic bit_open(
        input logic present,
        input logic grp_sec,
        input logic route_sec,
        input logic route_nsec,
        input logic ns_access,
        input logic sec_dis
    );
        logic routed;
        logic hidden;
        routed = grp_sec ? route_sec : route_nsec;
        hidden = ns_access && !sec_dis && grp_sec;
        return present && routed && !hidden;
    endfunction
endpackage

// File: rtl/sse_addr_decode.sv
// Address decoder: raises one select per register word when the address
// matches BASE_OFF + 4*(FIRST_IDX+k) exactly. Any other address, including
// misaligned ones, selects nothing.
module sse_addr_decode #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_REGS  = 2,
    parameter int unsigned BASE_OFF  = 'h100,
    parameter int unsigned FIRST_IDX = 1
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);
    // One exact comparator per word.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_cmp
        localparam int unsigned OFF = BASE_OFF + 4 * (FIRST_IDX + k);
        assign sel[k] = (addr == ADDR_W'(OFF));
    end

    // Any word selected.
    assign hit = |sel;
endmodule

// File: rtl/sse_access_mask.sv
// Access mask: one open/closed flag per interrupt for the current access.
// The mask depends on access security, group, presence and routing enables.
module sse_access_mask #(
    parameter int unsigned NUM_BITS = 64
) (
    input  logic [NUM_BITS-1:0] present,
    input  logic [NUM_BITS-1:0] grp_sec,
    input  logic                route_sec,
    input  logic                route_nsec,
    input  logic                ns_access,
    input  logic                sec_dis,
    output logic [NUM_BITS-1:0] open_mask
);
    import sse_pkg::*;

    // Per-bit evaluation of the shared access rule.
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
        assign open_mask[i] = bit_open(present[i], grp_sec[i], route_sec,
                                       route_nsec, ns_access, sec_dis);
    end
endmodule

// File: rtl/sse_enable_store.sv
// Enable storage: write-one-to-set words with a per-bit test clear.
// Assumes the caller supplies one-hot word selects and the access mask;
// a set beats a clear on the same bit in the same cycle.
module sse_enable_store #(
    parameter int unsigned NUM_REGS = 2,
    parameter int unsigned WORD_W   = 32,
    localparam int unsigned NUM_BITS = NUM_REGS * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] sel,
    input  logic                wr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [NUM_BITS-1:0] open_mask,
    input  logic [NUM_BITS-1:0] clr,
    output logic [NUM_BITS-1:0] en_q
);
    logic [NUM_BITS-1:0] set_vec;

    // Per-word set request, gated by select, strobe, data and mask.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
        assign set_vec[k*WORD_W +: WORD_W] =
            {WORD_W{wr && sel[k]}} & wdata & open_mask[k*WORD_W +: WORD_W];
    end

    // Enable register update: clear first, then set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q & ~clr) | set_vec;
    end

    // R2: an enable that was set and not cleared stays set.
    p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_q & $past(en_q & ~clr)) == $past(en_q & ~clr)));

    // R9: every requested set is present after the edge, clear or not.
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((en_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/sec_set_enable_bank.sv
// Set-enable register bank for an extended private interrupt range.
// Decodes the register port, masks each bit by access security, group,
// presence and routing, stores write-one-to-set enables and returns
// registered masked read data one cycle after the read strobe.
module sec_set_enable_bank #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_REGS  = 2,
    parameter int unsigned BASE_OFF  = 'h100,
    parameter int unsigned FIRST_IDX = 1,
    localparam int unsigned WORD_W   = sse_pkg::WORD_W,
    localparam int unsigned NUM_BITS = NUM_REGS * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [WORD_W-1:0]   acc_wdata,
    input  logic                acc_wr,
    input  logic                acc_rd,
    input  logic                acc_ns,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [NUM_BITS-1:0] irq_present,
    input  logic [NUM_BITS-1:0] irq_grp_sec,
    input  logic                sec_disable,
    input  logic                route_en_sec,
    input  logic                route_en_nsec,
    input  logic [NUM_BITS-1:0] test_clr,
    output logic [NUM_BITS-1:0] fwd_en
);
    import sse_pkg::*;

    logic [NUM_REGS-1:0] sel;
    logic                hit;
    logic [NUM_BITS-1:0] open_mask;
    logic [NUM_BITS-1:0] en_q;
    word_t               rd_word;

    sse_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
        .BASE_OFF(BASE_OFF), .FIRST_IDX(FIRST_IDX)
    ) i_dec (
        .addr(acc_addr), .sel(sel), .hit(hit)
    );

    sse_access_mask #(.NUM_BITS(NUM_BITS)) i_mask (
        .present(irq_present), .grp_sec(irq_grp_sec),
        .route_sec(route_en_sec), .route_nsec(route_en_nsec),
        .ns_access(acc_ns), .sec_dis(sec_disable), .open_mask(open_mask)
    );

    sse_enable_store #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) i_store (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(acc_wr),
        .wdata(acc_wdata), .open_mask(open_mask), .clr(test_clr),
        .en_q(en_q)
    );

    // Read mux: the selected word, masked; zero when nothing is selected.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (sel[k]) rd_word |= en_q[k*WORD_W +: WORD_W] & open_mask[k*WORD_W +: WORD_W];
        end
    end

    // Read data register: loaded on a read strobe, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (acc_rd) rd_data <= rd_word;
        else             rd_data <= '0;
    end

    assign fwd_en = en_q;

    // R8: no read, or a read that misses both words, returns zero.
    p_rd_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rd || !hit) |=> (rd_data == '0));

    // R6: a bit can only become set while its mask was open.
    p_closed_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fwd_en & ~$past(fwd_en) & ~$past(open_mask)) == '0));

    // R4: a reset cycle leaves every enable at zero.
    p_reset_clear_r4: assert property (@(posedge clk)
        !rst_n |=> (fwd_en == '0));
endmodule

// File: tb/test_sec_set_enable_bank.sv
`timescale 1ns/1ps
module test_sec_set_enable_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic        acc_ns = 1'b0;
    logic [31:0] rd_data;
    logic [63:0] irq_present = '1;
    logic [63:0] irq_grp_sec = '0;
    logic        sec_disable = 1'b0;
    logic        route_en_sec = 1'b1;
    logic        route_en_nsec = 1'b1;
    logic [63:0] test_clr = '0;
    logic [63:0] fwd_en;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R4";

    logic [63:0] model_en = '0;
    logic [31:0] model_rd = '0;

    sec_set_enable_bank i_sec_set_enable_bank (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_ns(acc_ns), .rd_data(rd_data),
        .irq_present(irq_present), .irq_grp_sec(irq_grp_sec),
        .sec_disable(sec_disable), .route_en_sec(route_en_sec),
        .route_en_nsec(route_en_nsec), .test_clr(test_clr), .fwd_en(fwd_en)
    );

    always #2.5 clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model: behavioural update at each edge, compared 1 ns later.
    always @(posedge clk) begin
        logic [63:0] opn;
        logic [63:0] nxt;
        logic [31:0] rdv;
        int          w;
        if (!rst_n) begin
            model_en = '0;
            model_rd = '0;
        end else begin
            for (int i = 0; i < 64; i++) begin
                logic routed;
                routed = irq_grp_sec[i] ? route_en_sec : route_en_nsec;
                opn[i] = irq_present[i] && routed &&
                         !(acc_ns && !sec_disable && irq_grp_sec[i]);
            end
            w = -1;
            if (acc_addr == 12'h104) w = 0;
            if (acc_addr == 12'h108) w = 1;
            rdv = '0;
            if (acc_rd && w >= 0)
                for (int b = 0; b < 32; b++) rdv[b] = model_en[w*32+b] & opn[w*32+b];
            nxt = model_en & ~test_clr;
            if (acc_wr && w >= 0)
                for (int b = 0; b < 32; b++)
                    if (acc_wdata[b] && opn[w*32+b]) nxt[w*32+b] = 1'b1;
            model_en = nxt;
            model_rd = rdv;
        end
        #1;
        check({cur_req, " fwd_en"}, fwd_en, model_en);
        check({cur_req, " rd_data"}, {32'h0, rd_data}, {32'h0, model_rd});
    end

    task automatic do_wr(logic [11:0] a, logic [31:0] d, logic ns);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_ns = ns; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0; acc_wdata = '0;
    endtask

    task automatic do_rd(logic [11:0] a, logic ns, output logic [31:0] v);
        @(negedge clk);
        acc_addr = a; acc_ns = ns; acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        v = rd_data;
    endtask

    task automatic pulse_clr(logic [63:0] c);
        @(negedge clk);
        test_clr = c;
        @(negedge clk);
        test_clr = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 reset enables", fwd_en, 64'h0);
        do_rd(12'h104, 1'b0, v);
        check("R4 reset read", {32'h0, v}, 64'h0);

        cur_req = "R2";
        do_wr(12'h104, 32'h0000_00F0, 1'b0);
        check("R2 set low word", fwd_en, 64'h0000_0000_0000_00F0);
        do_wr(12'h104, 32'h0, 1'b0);
        check("R2 zero write no effect", fwd_en, 64'h0000_0000_0000_00F0);
        cur_req = "R3";
        do_rd(12'h104, 1'b0, v);
        check("R3 read back", {32'h0, v}, 64'h0000_00F0);
        cur_req = "R1";
        do_wr(12'h108, 32'h8000_0001, 1'b0);
        check("R1 upper word position", fwd_en, 64'h8000_0001_0000_00F0);

        cur_req = "R9";
        pulse_clr('1);
        check("R9 clear all", fwd_en, 64'h0);

        cur_req = "R5";
        irq_grp_sec = 64'h0000_0F00_0000_0F00;
        do_wr(12'h104, 32'hFFFF_FFFF, 1'b1);
        check("R5 ns write skips secure", fwd_en, 64'h0000_0000_FFFF_F0FF);
        do_wr(12'h104, 32'h0000_0F00, 1'b0);
        check("R5 secure write", fwd_en, 64'h0000_0000_FFFF_FFFF);
        do_rd(12'h104, 1'b1, v);
        check("R5 ns read hides secure", {32'h0, v}, 64'hFFFF_F0FF);
        do_rd(12'h104, 1'b0, v);
        check("R5 secure read", {32'h0, v}, 64'hFFFF_FFFF);
        sec_disable = 1'b1;
        do_rd(12'h104, 1'b1, v);
        check("R5 disable flag opens", {32'h0, v}, 64'hFFFF_FFFF);
        sec_disable = 1'b0;
        irq_grp_sec = '0;
        pulse_clr('1);

        cur_req = "R6";
        irq_present = ~64'h0000_00FF_0000_0000;
        do_wr(12'h108, 32'hFFFF_FFFF, 1'b0);
        check("R6 absent not set", fwd_en, 64'hFFFF_FF00_0000_0000);
        do_rd(12'h108, 1'b0, v);
        check("R6 absent reads zero", {32'h0, v}, 64'hFFFF_FF00);
        irq_present = '1;
        pulse_clr('1);

        cur_req = "R7";
        route_en_nsec = 1'b0;
        irq_grp_sec = 64'h0000_0000_FFFF_0000;
        do_wr(12'h104, 32'hFFFF_FFFF, 1'b0);
        check("R7 unrouted not set", fwd_en, 64'h0000_0000_FFFF_0000);
        route_en_nsec = 1'b1;
        route_en_sec = 1'b0;
        do_rd(12'h104, 1'b0, v);
        check("R7 unrouted reads zero", {32'h0, v}, 64'h0);
        route_en_sec = 1'b1;
        irq_grp_sec = '0;
        pulse_clr('1);

        cur_req = "R8";
        do_wr(12'h100, 32'hFFFF_FFFF, 1'b0);
        do_wr(12'h10C, 32'hFFFF_FFFF, 1'b0);
        do_wr(12'h105, 32'hFFFF_FFFF, 1'b0);
        do_wr(12'h004, 32'hFFFF_FFFF, 1'b0);
        check("R8 stray writes ignored", fwd_en, 64'h0);
        do_wr(12'h104, 32'h0000_0003, 1'b0);
        do_rd(12'h100, 1'b0, v);
        check("R8 stray read zero", {32'h0, v}, 64'h0);
        do_rd(12'h105, 1'b0, v);
        check("R8 misaligned read zero", {32'h0, v}, 64'h0);

        cur_req = "R9";
        @(negedge clk);
        acc_addr = 12'h104; acc_wdata = 32'h1; acc_wr = 1'b1; test_clr = '1;
        @(negedge clk);
        acc_wr = 1'b0; test_clr = '0;
        check("R9 set beats clear", fwd_en, 64'h1);

        cur_req = "R2";
        for (int n = 0; n < 2000; n++) begin
            int unsigned pick;
            @(negedge clk);
            pick = $urandom_range(0, 5);
            case (pick)
                0, 1: acc_addr = 12'h104;
                2, 3: acc_addr = 12'h108;
                4:    acc_addr = 12'h100 + 12'($urandom_range(0, 15));
                default: acc_addr = 12'($urandom());
            endcase
            acc_wdata = $urandom();
            acc_wr = $urandom_range(0, 1) == 1;
            acc_rd = $urandom_range(0, 1) == 1;
            acc_ns = $urandom_range(0, 1) == 1;
            test_clr = {$urandom(), $urandom()} & {$urandom(), $urandom()} &
                       {$urandom(), $urandom()};
            if ($urandom_range(0, 15) == 0) begin
                irq_present = ~({$urandom(), $urandom()} & {$urandom(), $urandom()});
                irq_grp_sec = {$urandom(), $urandom()};
                sec_disable = $urandom_range(0, 3) == 0;
                route_en_sec = $urandom_range(0, 3) != 0;
                route_en_nsec = $urandom_range(0, 3) != 0;
            end
        end
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0; test_clr = '0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule